// File: doc/BRIEF.md
# Audio Control Register Target on I2C

This block is a write-only I2C target that holds the control settings of an audio processing path. It oversamples the SCL and SDA lines with the system clock and recognises START and STOP conditions on the bus. A transfer begins with START and a chip address byte. Only the write address 0x88 is accepted. The next byte is a subaddress, and any number of data bytes follow it. The slave pulls SDA low during the ninth clock of each byte that it accepts.

Each data byte is written into the register that the subaddress selects. A mode flag inside the subaddress byte decides what happens to the following bytes. With the flag clear, every byte goes to the same register. With the flag set, each byte goes to the next register in turn. Only the lower half of the subaddress range holds registers. Bytes aimed at the upper half are acknowledged and dropped, and the increment sequence carries on through them. All registers drive parallel outputs that the analogue controls can use directly.

Top module: `audctl_i2c_regs`

## Requirements
- R1: A synchronous active-high reset clears every control register to 0x00 and releases SDA, so `sda_pull_low` is 0.
- R2: A falling SDA while SCL is high (START) begins address reception. A rising SDA while SCL is high (STOP) returns the slave to idle. Bytes clocked in while idle are neither acknowledged nor written.
- R3: After START, if the first byte equals 0x88, the slave asserts `sda_pull_low` for the ninth SCL clock of that byte. It does the same for the subaddress byte and for every data byte of the transfer.
- R4: If the first byte after START is any other value, no byte of that transfer is acknowledged and no register changes until the next START.
- R5: Subaddress bit 4 is the increment flag and bits [3:0] select the register; bits [7:5] are ignored. With bit 4 at 0, every data byte of the transfer is written to the same register, so the last byte wins.
- R6: With bit 4 at 1, the first data byte goes to the sent subaddress and each further byte goes to the previous subaddress plus one.
- R7: A data byte aimed at subaddress 8 to 15 changes no register but is still acknowledged.
- R8: In increment mode the 4-bit subaddress wraps from 15 to 0.
- R9: A START seen part-way through a byte abandons that byte and restarts address reception. The partial byte writes nothing.
- R10: Bytes are shifted in most significant bit first, one bit per rising SCL edge.
- R11: Register k (0 to 7) appears on `ctrl_regs[8k+7:8k]` and keeps its value until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_pull_low | output | 1 | 1 means the pad must pull SDA low (acknowledge) |
| ctrl_regs | output | 64 | Concatenated control registers, register 0 in the low byte |

## Verification
A wrong byte phase or transfer state shows first on `sda_pull_low`, because the acknowledge slot comes at the end of every byte. A bit counter off by one or a mis-decoded address therefore shows within nine SCL periods. A wrong subaddress pointer or increment flag shows only on `ctrl_regs`, and only after the byte it misdirects has been written. For that reason the bench checks the registers after every transfer and chooses data bytes whose bit patterns are not symmetric.

// File: rtl/audctl_pkg.sv
package audctl_pkg;

    localparam int BYTE_W  = 8;
    localparam int SUB_W   = 4;
    localparam int INC_BIT = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } phase_e;

    // Bus events derived from the synchronised lines
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    // Write request from the byte engine to the register file
    typedef struct packed {
        logic              en;
        logic [SUB_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [SUB_W-1:0] next_sub(input logic [SUB_W-1:0] s,
                                                 input logic inc);
        return inc ? (s + 1'b1) : s;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import audctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    // bit 1 = SCL, bit 0 = SDA; idle bus is high
    logic [1:0] stage_q [STAGES];
    logic [1:0] prev_q;
    logic [1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            stage_q[0] <= {scl_in, sda_in};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur = stage_q[STAGES-1];

    always_comb begin
        ev.start    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
        ev.stop     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
        ev.scl_rise = cur[1] & ~prev_q[1];
        ev.scl_fall = ~cur[1] & prev_q[1];
        ev.sda      = cur[0];
    end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import audctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h88,
    parameter int                NUM_REGS = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    ack_drv,
    output wr_req_t wr
);

    localparam logic [3:0]     LAST_BIT  = 4'(BYTE_W);
    localparam logic [SUB_W:0] REG_LIMIT = (SUB_W+1)'(NUM_REGS);

    phase_e             phase;
    logic [3:0]         cnt;
    logic               in_ack;
    logic               ack_q;
    logic [BYTE_W-1:0]  shreg;
    logic [SUB_W-1:0]   ptr;
    logic               inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            in_ack <= 1'b0;
            ack_q  <= 1'b0;
            shreg  <= '0;
            ptr    <= '0;
            inc    <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                phase  <= PH_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                ack_q  <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                ack_q  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.scl_rise && !in_ack && cnt < LAST_BIT) begin
                    shreg <= {shreg[BYTE_W-2:0], ev.sda};
                    cnt   <= cnt + 1'b1;
                end else if (ev.scl_fall && in_ack) begin
                    in_ack <= 1'b0;
                    ack_q  <= 1'b0;
                    cnt    <= '0;
                end else if (ev.scl_fall && cnt == LAST_BIT) begin
                    in_ack <= 1'b1;
                    unique case (phase)
                        PH_ADDR: begin
                            if (shreg == DEV_ADDR) begin
                                ack_q <= 1'b1;
                                phase <= PH_SUB;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_SUB: begin
                            ack_q <= 1'b1;
                            ptr   <= shreg[SUB_W-1:0];
                            inc   <= shreg[INC_BIT];
                            phase <= PH_DATA;
                        end
                        PH_DATA: begin
                            ack_q <= 1'b1;
                            if ({1'b0, ptr} < REG_LIMIT) begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= shreg;
                            end
                            ptr <= next_sub(ptr, inc);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign ack_drv = ack_q;

    AST_ACK_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> (phase == PH_SUB || phase == PH_DATA)); // R3
    AST_ACK_HELD_TO_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_q) |-> $past(ev.scl_fall || ev.start || ev.stop)); // R3
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !ack_q); // R4
    AST_WRITE_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> phase == PH_DATA); // R5

endmodule

// File: rtl/audctl_regfile.sv
module audctl_regfile
    import audctl_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr,
    output logic [NUM_REGS*BYTE_W-1:0] flat_o
);

    localparam logic [SUB_W:0] REG_LIMIT = (SUB_W+1)'(NUM_REGS);

    logic [BYTE_W-1:0] reg_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) reg_q[i] <= '0;
        end else if (wr.en) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (wr.addr == i[SUB_W-1:0]) reg_q[i] <= wr.data;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
            assign flat_o[g*BYTE_W +: BYTE_W] = reg_q[g];
        end
    endgenerate

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> ({1'b0, wr.addr} < REG_LIMIT)); // R7
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(flat_o)); // R11

endmodule

// File: rtl/audctl_i2c_regs.sv
module audctl_i2c_regs
    import audctl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'h88,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull_low,
    output logic [NUM_REGS*8-1:0] ctrl_regs
);

    bus_ev_t ev;
    wr_req_t wr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_byte_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .ack_drv (sda_pull_low),
        .wr      (wr)
    );

    audctl_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .flat_o (ctrl_regs)
    );

endmodule

// File: tb/audctl_i2c_regs_test.sv
module audctl_i2c_regs_test;

    localparam int Q = 10;   // quarter-bit time in clocks
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic pull;
    logic [63:0] regs;
    wire  sda_bus = sda_m & ~pull;

    always #10 clk = ~clk;

    audctl_i2c_regs uut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .sda_pull_low (pull),
        .ctrl_regs    (regs)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [8];

    // {subaddress byte, data byte}
    localparam logic [15:0] VEC [NV] = '{
        16'h00A5, 16'h073C, 16'hE381, 16'h0AFF,
        16'h0501, 16'h0F77, 16'h0280, 16'hC65A
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int k = 0; k < 8; k++) f[k*8 +: 8] = model[k];
        return f;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b0;   wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  wait_clk(Q);
        scl = 1'b1; wait_clk(2*Q);
        scl = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        ack = (sda_bus === 1'b0);
        wait_clk(Q);
        scl = 1'b0;   wait_clk(Q);
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] s;
        for (int k = 0; k < 8; k++) model[k] = 8'h00;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R1: reset state
        check("R1 regs", regs, 64'h0);
        check("R1 pull", {63'h0, pull}, 64'h0);

        // Table walk: single-byte writes (R5 upper bits ignored, R7, R10, R11)
        for (int v = 0; v < NV; v++) begin
            s = VEC[v][15:8];
            bus_start();
            send_byte(8'h88, a); check("R3 addr ack", {63'h0, a}, 64'h1);
            send_byte(s, a);
            send_byte(VEC[v][7:0], a); check("R7 data ack", {63'h0, a}, 64'h1);
            bus_stop();
            if (s[3:0] < 4'd8) model[s[2:0]] = VEC[v][7:0];
            wait_clk(4);
            check("R10 R11 R5 table regs", regs, model_flat());
        end

        // R6: increment from subaddress 1
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h11, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        bus_stop();
        model[1] = 8'h11; model[2] = 8'h22; model[3] = 8'h33;
        wait_clk(4);
        check("R6 increment", regs, model_flat());

        // R8 / R7: start at 14, wrap past 15 to 0
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h1E, a);
        send_byte(8'hD1, a); check("R7 ack at sub 14", {63'h0, a}, 64'h1);
        send_byte(8'hD2, a); check("R7 ack at sub 15", {63'h0, a}, 64'h1);
        send_byte(8'hD3, a); send_byte(8'hD4, a);
        bus_stop();
        model[0] = 8'hD3; model[1] = 8'hD4;
        wait_clk(4);
        check("R8 wrap", regs, model_flat());

        // R5: no increment, last byte wins
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h04, a);
        send_byte(8'h10, a); send_byte(8'h20, a); send_byte(8'h30, a);
        bus_stop();
        model[4] = 8'h30;
        wait_clk(4);
        check("R5 same register", regs, model_flat());

        // R4: wrong address
        bus_start();
        send_byte(8'h8A, a); check("R4 no addr ack", {63'h0, a}, 64'h0);
        send_byte(8'h02, a); check("R4 no sub ack", {63'h0, a}, 64'h0);
        send_byte(8'h99, a); check("R4 no data ack", {63'h0, a}, 64'h0);
        bus_stop();
        wait_clk(4);
        check("R4 regs unchanged", regs, model_flat());

        // R9: START in the middle of a data byte
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h03, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'h88, a); check("R9 readdressed ack", {63'h0, a}, 64'h1);
        send_byte(8'h06, a);
        send_byte(8'h5E, a);
        bus_stop();
        model[6] = 8'h5E;
        wait_clk(4);
        check("R9 abort and restart", regs, model_flat());

        // R2: bytes after STOP without a new START
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h00, a);
        bus_stop();
        scl = 1'b0; wait_clk(Q);
        send_byte(8'h42, a); check("R2 idle no ack", {63'h0, a}, 64'h0);
        send_byte(8'h43, a);
        scl = 1'b1; wait_clk(Q);
        wait_clk(4);
        check("R2 idle regs unchanged", regs, model_flat());

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule